// File: doc/BRIEF.md
# Bootstrap Capacitor Refresh Sequencer

This block keeps the high-side bootstrap capacitor of a half-bridge gate driver charged while the PWM input sits in its mid-level (tri-state) idle condition. If the capacitor discharges during a long idle period, the high-side switch would not be fully enhanced on the next high pulse. The block watches two digitised comparator flags. One says the capacitor voltage has fallen to the lower threshold. The other says it has reached the upper threshold. While the voltage is low, the block issues a train of fixed-length low-side gate pulses, each followed by an equal rest interval, until the upper flag appears.

The sequencer is hysteretic. It starts only on the lower flag, and once running it keeps pulsing until the upper flag is seen, even if the lower flag clears. A valid PWM level (logic high or logic low) always wins. A driver that is disabled, or held in undervoltage lockout, does the same: the train stops within one cycle and the pulse timer restarts from zero. The low-side request output is merged by the surrounding logic into the low-side gate command. The active status output tells that logic a refresh train is in progress.

Top module: `bootRefreshSeq`

## Requirements
- R1: After reset, `lsReq` and `refreshActive` are both 0.
- R2: While idle, a cycle with `pwmState` in tri-state (2'b10 or 2'b11), `gateEn`=1, `bootLow`=1 and `bootHigh`=0 makes both `lsReq` and `refreshActive` 1 after the next clock edge.
- R3: While idle with `bootLow`=0, the block stays idle: both outputs remain 0.
- R4: A refresh train alternates `lsReq` high for exactly ON_CYCLES cycles and low for exactly OFF_CYCLES cycles, with `refreshActive` held at 1 throughout, and it repeats.
- R5: Once a train has started, it continues after `bootLow` returns to 0, until `bootHigh` is seen.
- R6: `bootHigh`=1 during a train, in either the on or the off phase, ends it at the next clock edge. A pulse in progress is cut short, and both outputs go to 0.
- R7: A valid PWM level (`pwmState` 2'b00 = low, 2'b01 = high) makes both outputs 0 after the next clock edge, whatever the capacitor flags say.
- R8: `gateEn`=0 (driver disabled or in undervoltage lockout) makes both outputs 0 after the next clock edge and prevents any start.
- R9: After a preemption, the next train begins with a full ON_CYCLES-long pulse, because the pulse timer restarts.
- R10: No train starts when `bootHigh` is 1, even if `bootLow` is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmState | input | 2 | Decoded PWM input: 00 low, 01 high, 10 or 11 tri-state |
| gateEn | input | 1 | Global gate enable; 0 when disabled or in undervoltage lockout |
| bootLow | input | 1 | Bootstrap voltage at or below the lower threshold |
| bootHigh | input | 1 | Bootstrap voltage at or above the upper threshold |
| lsReq | output | 1 | Low-side gate refresh request |
| refreshActive | output | 1 | A refresh train is in progress |

## Verification
On every cycle, the assertions check the following. A valid PWM level, a dropped enable or the upper flag each empty the sequencer one edge later. A qualified start produces a pulse at the next edge. An idle block without the lower flag stays idle. Counters in the checker confirm that no pulse or rest interval runs longer than its parameter.

Only the bench scenarios can show the rest. They confirm that pulse and rest lengths are exact rather than merely bounded, and that a train repeats after the rest. They also show that the train outlives a cleared lower flag, and that the timer truly restarts after preemption to give a full-length first pulse.

// File: rtl/bootRefreshPkg.sv
package bootRefreshPkg;

  typedef enum logic [1:0] {
    PWM_LOW     = 2'b00,
    PWM_HIGH    = 2'b01,
    PWM_TRI     = 2'b10,
    PWM_TRI_ALT = 2'b11
  } pwmState_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ON   = 2'b01,
    ST_OFF  = 2'b10
  } seqState_t;

  // strobes from control to the interval timer
  typedef struct packed {
    logic clear;
    logic run;
  } timerCmd_t;

endpackage

// File: rtl/bootRefreshTimer.sv
module bootRefreshTimer
  import bootRefreshPkg::*;
#(
  parameter int ON_CYCLES  = 40,
  parameter int OFF_CYCLES = 40
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCmd_t cmd,
  output logic      onDone,
  output logic      offDone
);
  localparam int MAX_CYCLES = (ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES;
  localparam int CW         = $clog2(MAX_CYCLES + 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          count <= '0;
    else if (cmd.clear) count <= '0;
    else if (cmd.run)   count <= count + 1'b1;
  end

  assign onDone  = (count == CW'(ON_CYCLES - 1));
  assign offDone = (count == CW'(OFF_CYCLES - 1));
endmodule

// File: rtl/bootRefreshCtrl.sv
module bootRefreshCtrl
  import bootRefreshPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwmTri,
  input  logic      gateEn,
  input  logic      bootLow,
  input  logic      bootHigh,
  input  logic      onDone,
  input  logic      offDone,
  output timerCmd_t cmd,
  output logic      lsReq,
  output logic      refreshActive
);
  seqState_t state, nextState;
  logic      allowed;

  assign allowed = pwmTri && gateEn && !bootHigh;

  always_comb begin
    nextState = state;
    if (!allowed) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (bootLow) nextState = ST_ON;
        ST_ON:   if (onDone)  nextState = ST_OFF;
        ST_OFF:  if (offDone) nextState = ST_ON;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.clear = (nextState != state) || (nextState == ST_IDLE);
    cmd.run   = !cmd.clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign lsReq         = (state == ST_ON);
  assign refreshActive = (state != ST_IDLE);
endmodule

// File: rtl/bootRefreshSeq.sv
module bootRefreshSeq
  import bootRefreshPkg::*;
#(
  parameter int ON_CYCLES  = 40,
  parameter int OFF_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwmState,
  input  logic       gateEn,
  input  logic       bootLow,
  input  logic       bootHigh,
  output logic       lsReq,
  output logic       refreshActive
);
  timerCmd_t timerCmd;
  logic      onDone, offDone, pwmTri;

  assign pwmTri = (pwmState == PWM_TRI) || (pwmState == PWM_TRI_ALT);

  bootRefreshCtrl ctrl (
    .clk(clk), .rstN(rstN), .pwmTri(pwmTri), .gateEn(gateEn),
    .bootLow(bootLow), .bootHigh(bootHigh), .onDone(onDone), .offDone(offDone),
    .cmd(timerCmd), .lsReq(lsReq), .refreshActive(refreshActive)
  );

  bootRefreshTimer #(.ON_CYCLES(ON_CYCLES), .OFF_CYCLES(OFF_CYCLES)) timer (
    .clk(clk), .rstN(rstN), .cmd(timerCmd), .onDone(onDone), .offDone(offDone)
  );
endmodule

// File: rtl/bootRefreshSeqChecker.sv
module bootRefreshSeqChecker #(
  parameter int ON_CYCLES  = 40,
  parameter int OFF_CYCLES = 40
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pwmState,
  input logic       gateEn,
  input logic       bootLow,
  input logic       bootHigh,
  input logic       lsReq,
  input logic       refreshActive
);
  localparam int RW = $clog2(((ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES) + 2);

  logic [RW-1:0] hiRun, loRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun <= '0;
      loRun <= '0;
    end else begin
      hiRun <= lsReq ? hiRun + 1'b1 : '0;
      loRun <= (refreshActive && !lsReq) ? loRun + 1'b1 : '0;
    end
  end

  // R4: neither phase outlasts its parameter
  always_ff @(posedge clk) begin
    if (rstN) begin
      a_r4_on_bound:  assert (hiRun <= RW'(ON_CYCLES));
      a_r4_off_bound: assert (loRun <= RW'(OFF_CYCLES));
    end
  end

  a_r7_pwm_preempt: assert property (@(posedge clk) disable iff (!rstN)
    !pwmState[1] |=> !refreshActive);

  a_r8_disable_stop: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn |=> !refreshActive);

  a_r6_upper_stop: assert property (@(posedge clk) disable iff (!rstN)
    bootHigh |=> !refreshActive);

  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (!refreshActive && pwmState[1] && gateEn && bootLow && !bootHigh) |=> lsReq);

  a_r3_stay_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!refreshActive && !bootLow) |=> !refreshActive);
endmodule

bind bootRefreshSeq bootRefreshSeqChecker #(.ON_CYCLES(ON_CYCLES), .OFF_CYCLES(OFF_CYCLES)) chk (.*);

// File: tb/bootRefreshSeq_test.sv
module bootRefreshSeq_test;
  localparam int ON_C  = 40;
  localparam int OFF_C = 40;
  localparam int NVEC  = 11;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pwmState = 2'b10;
  logic       gateEn = 1'b0;
  logic       bootLow = 1'b0;
  logic       bootHigh = 1'b0;
  logic       lsReq, refreshActive;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bootRefreshSeq #(.ON_CYCLES(ON_C), .OFF_CYCLES(OFF_C)) uut (
    .clk(clk), .rstN(rstN), .pwmState(pwmState), .gateEn(gateEn),
    .bootLow(bootLow), .bootHigh(bootHigh), .lsReq(lsReq), .refreshActive(refreshActive)
  );

  // {pwmState, gateEn, bootLow, bootHigh, expect lsReq, expect refreshActive}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b10_1_0_0_0_0, // R3 idle, no low flag
    7'b10_1_1_0_1_1, // R2 start
    7'b00_1_1_0_0_0, // R7 PWM low preempts
    7'b10_1_1_0_1_1, // R2 restart
    7'b01_1_1_0_0_0, // R7 PWM high preempts
    7'b10_0_1_0_0_0, // R8 disabled, no start
    7'b10_1_1_1_0_0, // R10 upper flag blocks start
    7'b10_1_1_0_1_1, // R2 start again
    7'b10_0_1_0_0_0, // R8 disable stops train
    7'b11_1_1_0_1_1, // R2 alternate tri-state code
    7'b10_1_0_1_0_0  // R6 upper flag truncates pulse
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int onCnt, offCnt;
    repeat (3) step();
    check("R1 lsReq after reset", lsReq, 0);
    check("R1 refreshActive after reset", refreshActive, 0);
    rstN = 1'b1;
    step();

    for (int i = 0; i < NVEC; i++) begin
      {pwmState, gateEn, bootLow, bootHigh} = VEC[i][6:2];
      step();
      check($sformatf("R2 R3 R6 R7 R8 R10 row %0d lsReq", i), lsReq, VEC[i][1]);
      check($sformatf("R2 R3 R6 R7 R8 R10 row %0d refreshActive", i), refreshActive, VEC[i][0]);
    end

    // R4 / R5: exact phase lengths, lower flag cleared after start
    pwmState = 2'b10; gateEn = 1'b1; bootLow = 1'b1; bootHigh = 1'b0;
    step();
    bootLow = 1'b0;
    onCnt = lsReq ? 1 : 0;
    for (int i = 0; i < 200 && lsReq; i++) begin
      step();
      if (lsReq) onCnt++;
    end
    check("R4 on length", onCnt, ON_C);
    offCnt = 0;
    for (int i = 0; i < 200 && refreshActive && !lsReq; i++) begin
      offCnt++;
      step();
    end
    check("R4 off length", offCnt, OFF_C);
    check("R5 train repeats after low flag cleared", lsReq, 1);

    // R6: upper flag during off phase
    for (int i = 0; i < 200 && lsReq; i++) step();
    bootHigh = 1'b1;
    step();
    check("R6 stop in off phase", refreshActive, 0);

    // R9: timer restarts after preemption
    bootHigh = 1'b0; bootLow = 1'b1;
    step();
    repeat (10) step();
    pwmState = 2'b00;
    step();
    check("R9 preempted", lsReq, 0);
    pwmState = 2'b10;
    step();
    onCnt = lsReq ? 1 : 0;
    for (int i = 0; i < 200 && lsReq; i++) begin
      step();
      if (lsReq) onCnt++;
    end
    check("R9 full first pulse after preemption", onCnt, ON_C);

    bootHigh = 1'b1;
    step();
    check("R6 idle after upper flag", refreshActive, 0);
    finishRun();
  end
endmodule